// File: doc/BRIEF.md
# Serial Front-End Configuration Master

This block sits in a module controller and configures up to sixteen front-end readout chips over a slow serial link. All chips share one broadcast serial data line and one load line. A slow protocol clock, derived from the system clock, times every bit on both lines. A transfer first shifts a command field and an address field with the load line low. It then shifts a data word with the load line high. While the data word is shifted, the block captures the same number of readback bits from the selected chip's own point-to-point serial input.

On the host side, a one-cycle start pulse presents a command, an address, a write payload and a chip select. The host sees a busy flag while the transfer runs. At the end it gets a one-cycle done pulse together with the captured readback word. While the data-taking flag is high, the configuration lines must stay quiet. A request made in that time is refused. A transfer already running is cut short. Either case raises an error flag.

The controller has four states:
- ST_IDLE goes to ST_ADDR on an accepted start.
- ST_ADDR goes to ST_DATA after the last command/address bit.
- ST_DATA goes to ST_DONE after the last data bit.
- ST_DONE goes to ST_IDLE after one cycle.
- ST_ADDR and ST_DATA both fall back to ST_IDLE when data taking starts (abort).

Top module: `cfg_serial_master`

## Requirements
- R1: After reset, busy, err, done, sclk_o, sdo_o and load_o are 0 and rd_data is all zeros.
- R2: While bits are shifted, sclk_o has a period of DIV (default 8) system clocks: low for the first half of each bit and high for the second half. Outside a transfer sclk_o stays low.
- R3: A transfer shifts exactly CMD_W+ADDR_W+DATA_W bits, all MSB first, in this order: the command field (CMD_W=5), then the address field (ADDR_W=4), both with load_o=0, then the data word (DATA_W=16) with load_o=1. The word on the line is therefore {cmd_word, addr_word, wr_data}.
- R4: sdo_o and load_o change only at the edge where sclk_o falls, or at the start of a transfer while sclk_o is low. They never change while sclk_o is high.
- R5: During the data phase, sdi_i[chip_sel] is sampled at each rising edge of sclk_o and shifted in MSB first. The inputs of all other chips have no effect. The first bit sampled becomes rd_data[15]. rd_data is updated, with a one-cycle done pulse, one system clock after the last bit period ends.
- R6: busy is high from the cycle after an accepted start until done. A start pulse while busy is ignored, and the running transfer is unchanged.
- R7: A start while run_active is high is refused: busy stays 0, sclk_o shows no edge, and err becomes 1.
- R8: If run_active rises during a transfer, the transfer is dropped. Within one system clock, sclk_o, sdo_o, load_o and busy return to 0. err becomes 1, no done pulse follows, and rd_data keeps its previous value.
- R9: An accepted start clears err.
- R10: In any cycle that follows a cycle with run_active high, sclk_o, sdo_o and load_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (protocol clock is derived from it) |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle transfer request |
| cmd_word | input | CMD_W | Command field, shifted first |
| addr_word | input | ADDR_W | Address field, shifted second |
| wr_data | input | DATA_W | Payload, shifted with load high |
| chip_sel | input | SEL_W | Chip whose readback input is captured |
| run_active | input | 1 | Data-taking flag; blocks and aborts transfers |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Last request refused or aborted |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_data | output | DATA_W | Captured readback word |
| sclk_o | output | 1 | Slow protocol clock to all chips |
| sdo_o | output | 1 | Broadcast serial data |
| load_o | output | 1 | 0 for command/address bits, 1 for data bits |
| sdi_i | input | N_CHIPS | Per-chip serial readback inputs |

## Verification
The assertions check on every cycle that the lines hold still while sclk_o is high, that sclk_o is low in ST_IDLE, and that the lines are quiet after data taking is seen. They also check the refusal and abort outcomes and that done is a single pulse. Only the bench scenarios can show the rest. These are the bit order and load tagging of the whole word, the exact protocol clock period, and that readback comes from the selected chip and from no other (shown by sweeping all sixteen selects against distinct patterns). They also include an ignored start mid-transfer, and clearing of err by a later request.

// File: rtl/cfgm_pkg.sv
`timescale 1ns/1ps
package cfgm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } cfgm_state_e;
endpackage

// File: rtl/cfgm_clkgen.sv
`timescale 1ns/1ps
module cfgm_clkgen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int HALF = DIV / 2;
    localparam int PW   = $clog2(DIV);

    logic [PW-1:0] ph;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph   <= '0;
            sclk <= 1'b0;
        end else begin
            ph <= (ph == PW'(DIV-1)) ? '0 : ph + 1'b1;
            if (ph == PW'(HALF-1))
                sclk <= 1'b1;
            else if (ph == PW'(DIV-1))
                sclk <= 1'b0;
        end
    end

    assign rise_stb = run && (ph == PW'(HALF-1));
    assign fall_stb = run && (ph == PW'(DIV-1));

    // R2: the protocol clock is never high in the first half of a bit period
    a_r2_low_first_half: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ph < PW'(HALF) && ph != '0) |-> !sclk);
endmodule

// File: rtl/cfgm_shifter.sv
`timescale 1ns/1ps
module cfgm_shifter #(
    parameter int TX_W = 25,
    parameter int RX_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            clr,
    input  logic            shift,
    input  logic            capture,
    input  logic [TX_W-1:0] tx_word,
    input  logic            rx_bit,
    output logic            sdo,
    output logic [RX_W-1:0] rx_word
);
    logic [TX_W-1:0] tx_sr;

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            tx_sr <= '0;
        else if (load)
            tx_sr <= tx_word;
        else if (shift)
            tx_sr <= {tx_sr[TX_W-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n || load)
            rx_word <= '0;
        else if (capture)
            rx_word <= {rx_word[RX_W-2:0], rx_bit};
    end

    assign sdo = tx_sr[TX_W-1];
endmodule

// File: rtl/cfg_serial_master.sv
`timescale 1ns/1ps
module cfg_serial_master
    import cfgm_pkg::*;
#(
    parameter int N_CHIPS = 16,
    parameter int CMD_W   = 5,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 16,
    parameter int DIV     = 8,
    parameter int SEL_W   = $clog2(N_CHIPS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CMD_W-1:0]   cmd_word,
    input  logic [ADDR_W-1:0]  addr_word,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [SEL_W-1:0]   chip_sel,
    input  logic               run_active,
    output logic               busy,
    output logic               err,
    output logic               done,
    output logic [DATA_W-1:0]  rd_data,
    output logic               sclk_o,
    output logic               sdo_o,
    output logic               load_o,
    input  logic [N_CHIPS-1:0] sdi_i
);
    localparam int CA_W = CMD_W + ADDR_W;
    localparam int TOT  = CA_W + DATA_W;
    localparam int CW   = $clog2(TOT + 1);

    cfgm_state_e      state, state_nx;
    logic [CW-1:0]    bit_cnt;
    logic [SEL_W-1:0] sel_q;
    logic             accept, refuse, shifting, abort, run;
    logic             rise_stb, fall_stb;
    logic [DATA_W-1:0] rx_word;

    assign shifting = (state == ST_ADDR) || (state == ST_DATA);
    assign accept   = (state == ST_IDLE) && start && !run_active;
    assign refuse   = (state == ST_IDLE) && start && run_active;
    assign abort    = shifting && run_active;
    assign run      = shifting && !run_active;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = ST_ADDR;
            ST_ADDR: begin
                if (run_active)
                    state_nx = ST_IDLE;
                else if (fall_stb && bit_cnt == CW'(CA_W-1))
                    state_nx = ST_DATA;
            end
            ST_DATA: begin
                if (run_active)
                    state_nx = ST_IDLE;
                else if (fall_stb && bit_cnt == CW'(TOT-1))
                    state_nx = ST_DONE;
            end
            ST_DONE: state_nx = ST_IDLE;
        endcase
    end

    // registered outputs and transfer bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            sel_q   <= '0;
            err     <= 1'b0;
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= (state == ST_DONE);
            if (state == ST_DONE)
                rd_data <= rx_word;
            if (accept) begin
                bit_cnt <= '0;
                sel_q   <= chip_sel;
                err     <= 1'b0;
            end else if (fall_stb) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (refuse || abort)
                err <= 1'b1;
        end
    end

    assign busy   = (state != ST_IDLE);
    assign load_o = (state == ST_DATA);

    cfgm_clkgen #(.DIV(DIV)) clkgen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sclk     (sclk_o),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    cfgm_shifter #(.TX_W(TOT), .RX_W(DATA_W)) shifter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .clr     (abort),
        .shift   (fall_stb),
        .capture (rise_stb && state == ST_DATA),
        .tx_word ({cmd_word, addr_word, wr_data}),
        .rx_bit  (sdi_i[sel_q]),
        .sdo     (sdo_o),
        .rx_word (rx_word)
    );

    // R2: protocol clock idle outside a transfer
    a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sclk_o);
    // R4: lines hold while the protocol clock is high
    a_r4_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> ($stable(sdo_o) && $stable(load_o)));
    // R10: lines quiet after data taking is seen
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run_active) |-> (!sclk_o && !sdo_o && !load_o));
    // R7: refused request leaves the master idle with err set
    a_r7_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        refuse |=> (!busy && err));
    // R8: abort drops the transfer without a done pulse
    a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && err && !done));
    // R5: done is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: a start in the middle of a transfer does not end it
    a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (shifting && start && !run_active) |=> busy);
endmodule

// File: tb/cfg_serial_master_tb_top.sv
`timescale 1ns/1ps
module cfg_serial_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  cmd_word = '0;
    logic [3:0]  addr_word = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  chip_sel = '0;
    logic        run_active = 1'b0;
    logic        busy, err, done, sclk_o, sdo_o, load_o;
    logic [15:0] rd_data;
    logic [15:0] sdi_i;

    logic [15:0] rb [16];
    int          dk = 0;
    int          edge_n = 0;
    int          per_bad = 0;
    int          done_cnt = 0;
    logic [31:0] cap = '0;
    logic [31:0] capld = '0;
    realtime     last_t = 0.0;
    int          n_checks = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    cfg_serial_master dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_word(cmd_word),
        .addr_word(addr_word), .wr_data(wr_data), .chip_sel(chip_sel),
        .run_active(run_active), .busy(busy), .err(err), .done(done),
        .rd_data(rd_data), .sclk_o(sclk_o), .sdo_o(sdo_o), .load_o(load_o),
        .sdi_i(sdi_i)
    );

    // front-end models: each chip presents its readback word MSB first
    always_comb begin
        for (int i = 0; i < 16; i++)
            sdi_i[i] = (dk < 16) ? rb[i][15 - dk] : 1'b0;
    end

    always @(posedge sclk_o) begin
        if (edge_n > 0 && ($realtime - last_t) != 64.0)
            per_bad++;
        last_t = $realtime;
        cap    = {cap[30:0], sdo_o};
        capld  = {capld[30:0], load_o};
        edge_n++;
        if (load_o) dk++;
    end

    always @(posedge clk) if (done) done_cnt++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic arm();
        dk = 0; edge_n = 0; per_bad = 0; cap = '0; capld = '0;
    endtask

    task automatic xfer(input int sel, input logic [4:0] c, input logic [3:0] a,
                        input logic [15:0] w, input bit poke);
        int d0;
        arm();
        d0 = done_cnt;
        @(negedge clk);
        chip_sel = 4'(sel); cmd_word = c; addr_word = a; wr_data = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R6 busy after start", 32'(busy), 32'd1);
        chk("R9 err cleared", 32'(err), 32'd0);
        if (poke) begin
            repeat (60) @(negedge clk);
            cmd_word = ~c; addr_word = ~a; wr_data = ~w;
            chip_sel = 4'(sel + 1); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        chk("R3 serial word", cap & 32'h1FF_FFFF, {7'd0, c, a, w});
        chk("R3 load tagging", capld & 32'h1FF_FFFF, 32'h0000_FFFF);
        chk("R3 bit count", 32'(edge_n), 32'd25);
        chk("R2 sclk period", 32'(per_bad), 32'd0);
        chk("R2 sclk idle low", 32'(sclk_o), 32'd0);
        chk("R5 readback word", 32'(rd_data), 32'(rb[sel]));
        chk("R5 one done pulse", 32'(done_cnt - d0), 32'd1);
        chk("R6 busy released", 32'(busy), 32'd0);
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++)
            rb[i] = 16'(i * 16'h1357) ^ 16'hC0DE;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 err", 32'(err), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 lines", {29'd0, sclk_o, sdo_o, load_o}, 32'd0);
        chk("R1 rd_data", 32'(rd_data), 32'd0);

        // R5 sweep over every chip select with distinct readback patterns
        for (int s = 0; s < 16; s++)
            xfer(s, 5'(s * 7 + 3), 4'(15 - s), 16'(s * 16'h0F1D) ^ 16'h5A3C, 1'b0);

        // R3 extremes: all-zero and all-one fields
        for (int i = 0; i < 16; i++) rb[i] = (i == 9) ? 16'h0000 : 16'hFFFF;
        xfer(9, 5'h1F, 4'hF, 16'hFFFF, 1'b0);
        for (int i = 0; i < 16; i++) rb[i] = (i == 0) ? 16'hFFFF : 16'h0000;
        xfer(0, 5'h00, 4'h0, 16'h0000, 1'b0);

        // R6 start pulse during a transfer has no effect
        for (int i = 0; i < 16; i++) rb[i] = 16'hB00B ^ 16'(i);
        xfer(5, 5'h15, 4'hA, 16'h3C96, 1'b1);

        // R7 refused start during data taking
        arm();
        @(negedge clk);
        run_active = 1'b1; start = 1'b1; chip_sel = 4'd2;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        chk("R7 busy stays low", 32'(busy), 32'd0);
        chk("R7 no sclk edge", 32'(edge_n), 32'd0);
        chk("R7 err set", 32'(err), 32'd1);
        chk("R10 lines quiet", {29'd0, sclk_o, sdo_o, load_o}, 32'd0);
        run_active = 1'b0;

        // R9 next accepted start clears err
        xfer(2, 5'h0A, 4'h5, 16'h1234, 1'b0);

        // R8 abort mid-transfer
        begin
            int d0;
            logic [15:0] prev;
            prev = rd_data;
            d0 = done_cnt;
            arm();
            @(negedge clk);
            chip_sel = 4'd7; cmd_word = 5'h1F; addr_word = 4'hF; wr_data = 16'hFFFF; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (100) @(negedge clk);
            run_active = 1'b1;
            @(negedge clk);
            chk("R8 lines idle", {29'd0, sclk_o, sdo_o, load_o}, 32'd0);
            chk("R8 busy dropped", 32'(busy), 32'd0);
            chk("R8 err set", 32'(err), 32'd1);
            repeat (300) @(negedge clk);
            chk("R8 no done", 32'(done_cnt - d0), 32'd0);
            chk("R8 rd_data kept", 32'(rd_data), 32'(prev));
            chk("R10 quiet during run", {29'd0, sclk_o, sdo_o, load_o}, 32'd0);
            run_active = 1'b0;
        end

        xfer(12, 5'h11, 4'h3, 16'h8001, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule